// File: doc/BRIEF.md
# I2C Serial Clock Generator with Clock Synchronization

This block produces the serial clock of an I2C master by counting cycles of the system clock. Two programmable counts set the length of the low phase and of the high phase. The SCL pin is open-drain and shared with other devices as a wired-AND line, so the block never drives the line high. It only asserts a drive-low request and lets the pull-up raise the line.

Two cases let other devices on the bus shape the clock. A slave that stretches the clock keeps the line low after the block has released it. The block then waits until it reads the line high before it starts timing the high phase. Another master with a faster clock may pull the line low while the block is counting its high phase. The block then ends its high phase at once and starts its own low phase, so that all masters stay on a common clock.

The sampled line goes through a small synchronizer before the state machine uses it. Single-cycle strobes mark the start of each high phase and each low phase, so that a bit engine can shift SDA at the right moments.

Top module: `scl_clkgen`

## Requirements
- R1: The SCL input reaches the state machine through a two-flop synchronizer. A change of the line sampled at edge n takes effect in the state at edge n+2, and the resulting strobe is visible after that edge.
- R2: Each low phase asserts `scl_drive_low` for exactly Leff consecutive cycles. Leff is the effective low count, and the phase starts in the cycle that carries `scl_fall_stb`.
- R3: When the low phase ends, the line is released and the high count does not start until the synchronized line reads high. On an unloaded bus, the time from `scl_fall_stb` to `scl_rise_stb` is Leff+3 cycles.
- R4: A high phase that no other device disturbs lasts Heff cycles. `scl_fall_stb` follows `scl_rise_stb` by exactly Heff cycles, where Heff is the effective high count.
- R5: If the line is seen low during the high phase, the block ends the phase early and starts its own low phase. The fall strobe and the drive-low appear 3 edges after the line falls, and the next low phase still lasts Leff cycles.
- R6: While another device holds the line low after the release (the high-wait state), the block neither drives the line nor emits a rise strobe. `scl_rise_stb` appears 3 edges after the line is released.
- R7: A count below 4 is treated as 4. Low and high counts of 1 and 2 give Leff = Heff = 4.
- R8: With `en` low, the block releases the line and returns to idle within one cycle, and the line input has no effect. One cycle after `en` rises, `scl_fall_stb` and `scl_drive_low` are both high.
- R9: During reset, `scl_drive_low`, `scl_rise_stb` and `scl_fall_stb` are all low.
- R10: Each strobe lasts one cycle, the two strobes are never high together, and `scl_fall_stb` always coincides with `scl_drive_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock generation enable |
| low_count | input | CNT_W | Low phase length in clock cycles (minimum 4) |
| high_count | input | CNT_W | High phase length in clock cycles (minimum 4) |
| scl_in | input | 1 | Level read back from the shared SCL line |
| scl_drive_low | output | 1 | Open-drain request to pull SCL low |
| scl_rise_stb | output | 1 | One-cycle strobe at the start of the high count |
| scl_fall_stb | output | 1 | One-cycle strobe at the start of the low drive |

## Verification
The embedded properties check the following on every cycle:
- the strobes are exclusive and last one cycle;
- a rise strobe only follows a high reading of the synchronized line;
- the high phase breaks off when the synchronized line is low;
- the block stays released in the high-wait state;
- the block goes idle one cycle after disable;
- the phase counter reloads and holds at zero.

Only the bench's scenarios can show the exact phase lengths for several count pairs, the clamping of small counts, and the three-edge latency of stretch release and early termination. They also show that the low phase keeps its full length after an early break.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    // Smallest legal phase length in system clock cycles
    localparam int MIN_PHASE = 4;
    // Default synchronizer depth on the SCL sense path
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_WAIT = 2'd2,
        ST_HIGH = 2'd3
    } scl_state_e;

    typedef struct packed {
        logic drive_low;
        logic rise;
        logic fall;
    } scl_out_t;

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scl_limit.sv
module scl_limit
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] lo_raw,
    input  logic [CNT_W-1:0] hi_raw,
    output logic [CNT_W-1:0] lo_load,
    output logic [CNT_W-1:0] hi_load
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_PHASE);

    logic [CNT_W-1:0] lo_eff;
    logic [CNT_W-1:0] hi_eff;

    always_comb begin
        lo_eff  = (lo_raw < FLOOR) ? FLOOR : lo_raw;
        hi_eff  = (hi_raw < FLOOR) ? FLOOR : hi_raw;
        // Counter runs from eff-1 down to zero: eff cycles per phase
        lo_load = lo_eff - CNT_W'(1);
        hi_load = hi_eff - CNT_W'(1);
    end
endmodule

// File: rtl/scl_down_counter.sv
module scl_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)       cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
    end

    assign done = (cnt == '0);

    // R4: a reload takes exactly the requested start value
    p_reload_value_r4: assert property (@(posedge clk) disable iff (rst)
        (load && !clr) |=> (cnt == $past(load_val)));

    // R2: an expired counter stays at zero until reloaded
    p_hold_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !load && !clr) |=> done);
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             scl_s,
    input  logic             cnt_done,
    input  logic [CNT_W-1:0] lo_load,
    input  logic [CNT_W-1:0] hi_load,
    output logic             cnt_clr,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output scl_out_t         outs
);
    scl_state_e state, nxt;
    logic       pick_high;
    logic       rise_q, fall_q;

    always_comb begin
        nxt       = state;
        cnt_load  = 1'b0;
        pick_high = 1'b0;
        if (!en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    nxt      = ST_LOW;
                    cnt_load = 1'b1;
                end
                ST_LOW: begin
                    if (cnt_done) nxt = ST_WAIT;
                end
                ST_WAIT: begin
                    if (scl_s) begin
                        nxt       = ST_HIGH;
                        cnt_load  = 1'b1;
                        pick_high = 1'b1;
                    end
                end
                ST_HIGH: begin
                    // Another master pulling low or own count expiring
                    if (!scl_s || cnt_done) begin
                        nxt      = ST_LOW;
                        cnt_load = 1'b1;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    assign cnt_clr = !en;
    assign cnt_val = pick_high ? hi_load : lo_load;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            state  <= nxt;
            rise_q <= (nxt == ST_HIGH) && (state != ST_HIGH);
            fall_q <= (nxt == ST_LOW) && (state != ST_LOW);
        end
    end

    always_comb begin
        outs.drive_low = (state == ST_LOW);
        outs.rise      = rise_q;
        outs.fall      = fall_q;
    end

    // R10: strobes never overlap
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(rise_q && fall_q));

    // R10: rise strobe is a single-cycle pulse
    p_rise_single_r10: assert property (@(posedge clk) disable iff (rst)
        rise_q |=> !rise_q);

    // R10: fall strobe coincides with the start of drive-low
    p_fall_drives_r10: assert property (@(posedge clk) disable iff (rst)
        fall_q |-> outs.drive_low);

    // R3: high counting starts only after the synchronized line read high
    p_rise_after_high_r3: assert property (@(posedge clk) disable iff (rst)
        rise_q |-> $past(scl_s));

    // R5: a low line during the high phase ends it on the next edge
    p_early_end_r5: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_HIGH && !scl_s) |=> fall_q);

    // R6: high-wait keeps the line released while it reads low
    p_wait_released_r6: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_WAIT && !scl_s) |=> (state == ST_WAIT && !outs.drive_low && !rise_q));

    // R8: disabling returns to idle and silences the outputs
    p_disable_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state == ST_IDLE && !outs.drive_low && !rise_q && !fall_q));
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] low_count,
    input  logic [CNT_W-1:0] high_count,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             scl_rise_stb,
    output logic             scl_fall_stb
);
    logic             scl_s;
    logic [CNT_W-1:0] lo_load, hi_load, cnt_val;
    logic             cnt_clr, cnt_load, cnt_done;
    scl_out_t         outs;

    scl_sync #(.STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (scl_in),
        .q   (scl_s)
    );

    scl_limit #(.CNT_W(CNT_W)) u_limit (
        .lo_raw  (low_count),
        .hi_raw  (high_count),
        .lo_load (lo_load),
        .hi_load (hi_load)
    );

    scl_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (cnt_clr),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .scl_s    (scl_s),
        .cnt_done (cnt_done),
        .lo_load  (lo_load),
        .hi_load  (hi_load),
        .cnt_clr  (cnt_clr),
        .cnt_load (cnt_load),
        .cnt_val  (cnt_val),
        .outs     (outs)
    );

    assign scl_drive_low = outs.drive_low;
    assign scl_rise_stb  = outs.rise;
    assign scl_fall_stb  = outs.fall;
endmodule

// File: tb/scl_clkgen_tb.sv
module scl_clkgen_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [W-1:0] low_count  = 16'd6;
    logic [W-1:0] high_count = 16'd9;
    logic         ext_low = 1'b0;
    logic         scl_line;
    logic         drv, rise, fall;
    int           checks = 0;
    int           errors = 0;
    bit           done_flag = 1'b0;

    // Wired-AND bus with pull-up
    assign scl_line = ~(drv | ext_low);

    scl_clkgen #(.CNT_W(W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .en            (en),
        .low_count     (low_count),
        .high_count    (high_count),
        .scl_in        (scl_line),
        .scl_drive_low (drv),
        .scl_rise_stb  (rise),
        .scl_fall_stb  (fall)
    );

    always #10 clk = ~clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Steps until the chosen strobe is seen; returns the step count
    task automatic wait_strobe(input bit want_rise, output int n);
        n = 0;
        while (!(want_rise ? rise : fall) && n < 2000) begin
            step();
            n++;
        end
    endtask

    // From a fall sample: count drive-low cycles and steps up to the rise
    task automatic measure_low(output int d, output int n);
        d = 0;
        n = 0;
        while (!rise && n < 2000) begin
            if (drv) d++;
            if (rise && fall) d = -100;
            step();
            n++;
        end
    endtask

    task automatic start_cfg(input int lo, input int hi);
        en = 1'b0;
        step();
        low_count  = W'(lo);
        high_count = W'(hi);
        en = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        check(drv == 1'b0, "R9 drive_low in reset", int'(drv), 0);
        check(rise == 1'b0 && fall == 1'b0, "R9 strobes in reset", int'(rise | fall), 0);
        rst = 1'b0;
        step();
    endtask

    task automatic t_free_run(input int lo, input int hi, input int leff, input int heff, input string tag);
        int n, d;
        start_cfg(lo, hi);
        wait_strobe(1'b0, n);
        check(fall && drv, {tag, " R10 fall with drive"}, int'(fall & drv), 1);
        measure_low(d, n);
        check(d == leff, {tag, " R2 low length"}, d, leff);
        check(n == leff + 3, {tag, " R3 fall-to-rise"}, n, leff + 3);
        check(!fall && !drv, {tag, " R10 rise alone"}, int'(fall | drv), 0);
        step();
        check(!rise, {tag, " R10 rise one cycle"}, int'(rise), 0);
        wait_strobe(1'b0, n);
        check(n + 1 == heff, {tag, " R4 high length"}, n + 1, heff);
        measure_low(d, n);
        check(d == leff && n == leff + 3, {tag, " R2 second low"}, d, leff);
    endtask

    task automatic t_stretch();
        int n;
        bit bad;
        start_cfg(6, 10);
        wait_strobe(1'b0, n);
        ext_low = 1'b1;
        bad = 1'b0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (rise) bad = 1'b1;
            if (i >= 6 && drv) bad = 1'b1;
        end
        check(!bad, "R6 no rise or drive while held", int'(bad), 0);
        ext_low = 1'b0;
        wait_strobe(1'b1, n);
        check(n == 3, "R1 R6 rise after release", n, 3);
    endtask

    task automatic t_early();
        int n, d;
        start_cfg(6, 40);
        wait_strobe(1'b1, n);
        step();
        step();
        ext_low = 1'b1;
        wait_strobe(1'b0, n);
        check(n == 3, "R5 early fall latency", n, 3);
        check(drv == 1'b1, "R5 drive after early fall", int'(drv), 1);
        ext_low = 1'b0;
        measure_low(d, n);
        check(d == 6, "R5 full low after early end", d, 6);
        check(n == 9, "R5 fall-to-rise after early end", n, 9);
    endtask

    task automatic t_disable();
        int n;
        bit bad;
        start_cfg(8, 8);
        wait_strobe(1'b1, n);
        step();
        en = 1'b0;
        step();
        check(!drv && !rise && !fall, "R8 idle one cycle after disable", int'(drv | rise | fall), 0);
        bad = 1'b0;
        for (int i = 0; i < 6; i++) begin
            ext_low = (i % 2 == 0);
            step();
            if (drv || rise || fall) bad = 1'b1;
        end
        ext_low = 1'b0;
        check(!bad, "R8 line ignored while disabled", int'(bad), 0);
        repeat (3) step();
        en = 1'b1;
        step();
        check(fall && drv, "R8 restart with fall", int'(fall & drv), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_free_run(6, 9, 6, 9, "base");
        t_free_run(12, 5, 12, 5, "skew");
        t_free_run(4, 4, 4, 4, "min");
        t_free_run(1, 2, 4, 4, "R7 clamp");
        t_stretch();
        t_early();
        t_disable();
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule